// File: doc/BRIEF.md
# Two-Channel Bus-Master Register Bank

This block holds the byte-wide control registers of a disk controller with two channels. Each channel has a command byte, a status byte and a timing byte of its own. One mode byte is shared by both channels. The mode byte records a pending interrupt for each channel and holds one mask bit per channel. The block merges the two channel requests into a single level-sensitive interrupt line.

Software reaches the registers through a simple access port: a strobe, a write flag, an address, a size code, write data and registered read data. The DMA engine beside the block does three things with it. It receives a one-cycle start pulse when software sets the start bit of a channel's command byte. It reports a busy level and error and done pulses, and these land in that channel's status byte. The task-file registers and the descriptor address ports are handled elsewhere. This block only keeps the descriptor port offsets free.

Top module: `bm_regbank`

## Requirements
- R1: Only byte accesses are honoured, which is size code 0. A read of size code 1 returns 0x0000FFFF, and a read of size code 2 or 3 returns 0xFFFFFFFF (ones across the access width, capped at the data width). A write with a size code other than 0 changes no register.
- R2: Address bit 3 selects the channel: offsets 0 to 3 are channel 0 and offsets 8 to 11 are channel 1. Address bits 1:0 select the register: 0 is command, 1 is the shared mode byte, 2 is status, 3 is timing. Offsets 4 to 7 and 12 to 15 are the descriptor ports, which live outside the block. Byte reads there return 0, and writes there change nothing.
- R3: A status write loads bits 5 and 6 from the data and clears bit 1 or bit 2 where the data holds a 1. Bits 3, 4 and 7 read as 0. Bit 0 ignores writes and mirrors the channel's engine-busy input one cycle later. An error pulse sets bit 1 and a done pulse sets bit 2. When a pulse and a clearing write fall in the same cycle, the pulse wins.
- R4: A mode write changes only bits 4 and 5. Bit 4 masks channel 0 and bit 5 masks channel 1. Both channel windows address the same mode byte.
- R5: Mode bit 2 follows channel 0's interrupt request and bit 3 follows channel 1's, each one cycle after the input.
- R6: The interrupt output is high exactly when (mode bit 2 is set and bit 4 is clear) or (bit 3 is set and bit 5 is clear). It changes in the same cycle as the mode byte.
- R7: Each channel's timing byte stores the full written byte and reads it back. A timing write to one channel leaves the other channel's timing byte unchanged.
- R8: After reset, every register reads 0, the interrupt output is low and no start pulse is active.
- R9: A command write stores the byte. If it takes bit 0 from 0 to 1, it raises that channel's start output for exactly the following cycle. Writing bit 0 as 1 when it is already 1 gives no pulse.
- R10: Read data and a read-valid flag appear one cycle after a read strobe. Reads leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | ADDR_W | Byte offset within the bank |
| acc_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| acc_wdata | input | DATA_W | Write data, byte in bits 7:0 |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High for the cycle in which rd_data answers a read |
| irq_req | input | 2 | Interrupt request level of each channel |
| eng_busy | input | 2 | Engine busy level of each channel |
| eng_err | input | 2 | Engine error pulse of each channel |
| eng_done | input | 2 | Engine done pulse of each channel |
| dma_start | output | 2 | One-cycle start pulse to the DMA engine of each channel |
| irq_out | output | 1 | Merged level-sensitive interrupt |

## Verification
Two pairs of events can fall in the same cycle, and both are driven on purpose. First, an engine error pulse arrives in the same cycle as a status write that would clear bit 1. A later read must show bit 1 still set, and only a second clearing write with no pulse removes it. Second, a channel's interrupt request rises in the same cycle as a mode write that masks that channel. The bench checks that the mode byte reads 0x14 and that the interrupt output never rises.

// File: rtl/bm_regbank_pkg.sv
package bm_regbank_pkg;
   localparam int NUM_CH   = 2;
   localparam int BYTE_W   = 8;
   localparam int PEND_LSB = 2;
   localparam int MASK_LSB = 4;

   typedef enum logic [1:0] {
      SEL_CMD  = 2'd0,
      SEL_MODE = 2'd1,
      SEL_STS  = 2'd2,
      SEL_TIM  = 2'd3
   } reg_sel_e;

   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bm_regbank_chan.sv
module bm_regbank_chan
   import bm_regbank_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_cmd,
   input  logic  wr_sts,
   input  logic  wr_tim,
   input  byte_t wdata,
   input  logic  eng_busy,
   input  logic  eng_err,
   input  logic  eng_done,
   output byte_t cmd_q,
   output byte_t sts_q,
   output byte_t tim_q,
   output logic  start_o
);
   byte_t sts_n;

   always_comb begin
      sts_n    = '0;
      sts_n[0] = eng_busy;
      if (eng_err)                sts_n[1] = 1'b1;
      else if (wr_sts & wdata[1]) sts_n[1] = 1'b0;
      else                        sts_n[1] = sts_q[1];
      if (eng_done)               sts_n[2] = 1'b1;
      else if (wr_sts & wdata[2]) sts_n[2] = 1'b0;
      else                        sts_n[2] = sts_q[2];
      sts_n[6:5] = wr_sts ? wdata[6:5] : sts_q[6:5];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         sts_q   <= '0;
         tim_q   <= '0;
         start_o <= 1'b0;
      end else begin
         sts_q   <= sts_n;
         start_o <= wr_cmd & wdata[0] & ~cmd_q[0];
         if (wr_cmd) cmd_q <= wdata;
         if (wr_tim) tim_q <= wdata;
      end
   end
endmodule

// File: rtl/bm_regbank_mode.sv
module bm_regbank_mode
   import bm_regbank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_mode,
   input  byte_t             wdata,
   input  logic [NUM_CH-1:0] irq_req,
   output byte_t             mode_q,
   output logic              irq_o
);
   logic [NUM_CH-1:0] live;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[PEND_LSB+c] <= 1'b0;
            mode_q[MASK_LSB+c] <= 1'b0;
         end else begin
            mode_q[PEND_LSB+c] <= irq_req[c];
            if (wr_mode) mode_q[MASK_LSB+c] <= wdata[MASK_LSB+c];
         end
      end
      assign live[c] = mode_q[PEND_LSB+c] & ~mode_q[MASK_LSB+c];
   end

   assign mode_q[PEND_LSB-1:0]              = '0;
   assign mode_q[BYTE_W-1:MASK_LSB+NUM_CH] = '0;
   assign irq_o = |live;
endmodule

// File: rtl/bm_regbank_rdmux.sv
module bm_regbank_rdmux
   import bm_regbank_pkg::*;
(
   input  logic  hit,
   input  logic  ch,
   input  logic [1:0] sel,
   input  byte_t mode_q,
   input  logic [NUM_CH-1:0][BYTE_W-1:0] cmd_all,
   input  logic [NUM_CH-1:0][BYTE_W-1:0] sts_all,
   input  logic [NUM_CH-1:0][BYTE_W-1:0] tim_all,
   output byte_t rd_byte
);
   always_comb begin
      rd_byte = '0;
      if (hit) begin
         unique case (reg_sel_e'(sel))
            SEL_CMD:  rd_byte = cmd_all[ch];
            SEL_MODE: rd_byte = mode_q;
            SEL_STS:  rd_byte = sts_all[ch];
            SEL_TIM:  rd_byte = tim_all[ch];
            default:  rd_byte = '0;
         endcase
      end
   end
endmodule

// File: rtl/bm_regbank.sv
module bm_regbank
   import bm_regbank_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [1:0]        acc_size,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic [1:0]        irq_req,
   input  logic [1:0]        eng_busy,
   input  logic [1:0]        eng_err,
   input  logic [1:0]        eng_done,
   output logic [1:0]        dma_start,
   output logic              irq_out
);
   localparam int NBYTES = DATA_W / BYTE_W;

   if (DATA_W < BYTE_W || DATA_W % BYTE_W != 0) begin : g_bad_data
      $error("bm_regbank: DATA_W must be a multiple of 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("bm_regbank: ADDR_W must be at least 4");
   end

   logic  in_bank, byte_acc, reg_hit, wr_hit;
   logic  ch;
   logic [1:0] sel;
   byte_t mode_q, rd_byte;
   logic [NUM_CH-1:0][BYTE_W-1:0] cmd_all, sts_all, tim_all;

   if (ADDR_W > 4) begin : g_hi
      assign in_bank = ~|acc_addr[ADDR_W-1:4];
   end else begin : g_lo
      assign in_bank = 1'b1;
   end

   assign ch       = acc_addr[3];
   assign sel      = acc_addr[1:0];
   assign byte_acc = (acc_size == 2'd0);
   assign reg_hit  = in_bank & ~acc_addr[2];
   assign wr_hit   = acc_en & acc_wr & byte_acc & reg_hit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic mine;
      assign mine = wr_hit & (ch == c[0]);
      bm_regbank_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_cmd   (mine & (sel == SEL_CMD)),
         .wr_sts   (mine & (sel == SEL_STS)),
         .wr_tim   (mine & (sel == SEL_TIM)),
         .wdata    (acc_wdata[BYTE_W-1:0]),
         .eng_busy (eng_busy[c]),
         .eng_err  (eng_err[c]),
         .eng_done (eng_done[c]),
         .cmd_q    (cmd_all[c]),
         .sts_q    (sts_all[c]),
         .tim_q    (tim_all[c]),
         .start_o  (dma_start[c])
      );
   end

   bm_regbank_mode u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_mode (wr_hit & (sel == SEL_MODE)),
      .wdata   (acc_wdata[BYTE_W-1:0]),
      .irq_req (irq_req),
      .mode_q  (mode_q),
      .irq_o   (irq_out)
   );

   bm_regbank_rdmux u_rdmux (
      .hit     (reg_hit),
      .ch      (ch),
      .sel     (sel),
      .mode_q  (mode_q),
      .cmd_all (cmd_all),
      .sts_all (sts_all),
      .tim_all (tim_all),
      .rd_byte (rd_byte)
   );

   function automatic logic [DATA_W-1:0] wide_ones(input logic [1:0] sz);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int b = 0; b < NBYTES; b++)
         if (b < (1 << sz)) m[b*BYTE_W +: BYTE_W] = '1;
      return m;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= acc_en & ~acc_wr;
         if (acc_en & ~acc_wr)
            rd_data <= byte_acc ? DATA_W'(rd_byte) : wide_ones(acc_size);
      end
   end
endmodule

// File: rtl/bm_regbank_chk.sv
module bm_regbank_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_size,
   input logic [DATA_W-1:0] acc_wdata,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic [1:0]        irq_req,
   input logic [1:0]        eng_busy,
   input logic [1:0]        dma_start,
   input logic              irq_out,
   input logic [7:0]        mode_q,
   input logic [1:0][7:0]   sts_all
);
   function automatic logic [DATA_W-1:0] ones_of(input logic [1:0] sz);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int b = 0; b < DATA_W/8; b++)
         if (b < (1 << sz)) m[b*8 +: 8] = '1;
      return m;
   endfunction

   assert_wide_read_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && acc_size != 2'd0) |=> (rd_data == ones_of($past(acc_size))));

   assert_busy_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) or 1'b1 |=> (sts_all[0][0] == $past(eng_busy[0]) && sts_all[1][0] == $past(eng_busy[1])));

   assert_sts_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_all[0][4:3] == 2'b00 && !sts_all[0][7] && sts_all[1][4:3] == 2'b00 && !sts_all[1][7]));

   assert_mode_fixed_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[7:6] == 2'b00 && mode_q[1:0] == 2'b00));

   assert_pend_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en || !acc_en |=> (mode_q[3:2] == $past(irq_req)));

   assert_irq_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (mode_q[2] || mode_q[3]));

   assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[0] |-> $past(acc_en && acc_wr && acc_size == 2'd0 && acc_addr == ADDR_W'(0) && acc_wdata[0]));

   assert_start_onecycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dma_start[1] |=> !dma_start[1]);

   assert_rd_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr) |=> rd_valid);

   assert_rd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(acc_en && !acc_wr));
endmodule

bind bm_regbank bm_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_en    (acc_en),
   .acc_wr    (acc_wr),
   .acc_addr  (acc_addr),
   .acc_size  (acc_size),
   .acc_wdata (acc_wdata),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .irq_req   (irq_req),
   .eng_busy  (eng_busy),
   .dma_start (dma_start),
   .irq_out   (irq_out),
   .mode_q    (mode_q),
   .sts_all   (sts_all)
);

// File: tb/bm_regbank_test.sv
module bm_regbank_test;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0, acc_wr = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [1:0]    acc_size = '0;
   logic [DW-1:0] acc_wdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic [1:0]    irq_req = '0, eng_busy = '0, eng_err = '0, eng_done = '0;
   logic [1:0]    dma_start;
   logic          irq_out;

   int total = 0;
   int bad = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];
   bit            done = 1'b0;

   always #4 clk = ~clk;

   bm_regbank #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .rd_data(rd_data), .rd_valid(rd_valid), .irq_req(irq_req),
      .eng_busy(eng_busy), .eng_err(eng_err), .eng_done(eng_done),
      .dma_start(dma_start), .irq_out(irq_out)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read results as the design answers
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) check("R10 unexpected rd_valid", 1, 0);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
      @(negedge clk);
      acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = {24'hABCDEF, d}; acc_size = sz;
      @(negedge clk);
      acc_en = 0; acc_wr = 0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag, input logic [1:0] sz = 2'd0);
      @(negedge clk);
      acc_en = 1; acc_wr = 0; acc_addr = a; acc_size = sz;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk);
      acc_en = 0;
   endtask

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R8 reset state
      check("R8 irq_out", DW'(irq_out), 0);
      check("R8 dma_start", DW'(dma_start), 0);
      for (int a = 0; a < 16; a++) rd(AW'(a), 0, "R8 reset read");

      // R1 wide accesses
      rd(4'd0, 32'h0000FFFF, "R1 half read", 2'd1);
      rd(4'd3, 32'hFFFFFFFF, "R1 word read", 2'd2);
      rd(4'd9, 32'hFFFFFFFF, "R1 dword read", 2'd3);
      wr(4'd3, 8'hAB, 2'd1);
      wr(4'd0, 8'h01, 2'd2);
      check("R1 wide write no start", DW'(dma_start), 0);
      rd(4'd3, 0, "R1 wide write ignored");

      // R7 timing per channel
      wr(4'd3, 8'hA5);
      wr(4'd11, 8'h3C);
      rd(4'd3, 32'hA5, "R7 ch0 timing");
      rd(4'd11, 32'h3C, "R7 ch1 timing");

      // R9 start pulses
      wr(4'd0, 8'h01);
      check("R9 ch0 pulse", DW'(dma_start), 32'h1);
      @(negedge clk);
      check("R9 pulse one cycle", DW'(dma_start), 0);
      wr(4'd0, 8'h09);
      check("R9 no pulse when already set", DW'(dma_start), 0);
      rd(4'd0, 32'h09, "R9 cmd stored");
      wr(4'd0, 8'h00);
      wr(4'd8, 8'h81);
      check("R9 ch1 pulse", DW'(dma_start), 32'h2);
      rd(4'd8, 32'h81, "R9 ch1 cmd");

      // R2 descriptor offsets
      wr(4'd12, 8'hFF);
      wr(4'd4, 8'hFF);
      rd(4'd12, 0, "R2 desc read zero");
      rd(4'd11, 32'h3C, "R2 desc write no effect");
      rd(4'd3, 32'hA5, "R2 desc write no effect ch0");

      // R4 mode write only touches mask bits, shared
      wr(4'd1, 8'hFF);
      rd(4'd1, 32'h30, "R4 mode masked write");
      rd(4'd9, 32'h30, "R4 mode shared");
      wr(4'd9, 8'h00);
      rd(4'd1, 0, "R4 mode cleared via ch1");

      // R5 / R6 interrupt merge
      @(negedge clk); irq_req = 2'b01;
      @(negedge clk);
      check("R6 irq ch0 unmasked", DW'(irq_out), 1);
      rd(4'd1, 32'h04, "R5 pend ch0");
      wr(4'd1, 8'h10);
      check("R6 irq masked", DW'(irq_out), 0);
      irq_req = 2'b11;
      @(negedge clk);
      check("R6 irq ch1", DW'(irq_out), 1);
      rd(4'd1, 32'h1C, "R5 both pend");
      wr(4'd1, 8'h30);
      check("R6 both masked", DW'(irq_out), 0);
      irq_req = 2'b00;
      @(negedge clk);
      rd(4'd1, 32'h30, "R5 pend cleared");
      wr(4'd1, 8'h00);
      // collision: request rises with the masking write
      @(negedge clk);
      irq_req = 2'b01; acc_en = 1; acc_wr = 1; acc_addr = 4'd1; acc_wdata = 32'h10; acc_size = 0;
      @(negedge clk);
      acc_en = 0; acc_wr = 0;
      check("R6 collision irq low", DW'(irq_out), 0);
      rd(4'd1, 32'h14, "R4 R5 collision mode");
      irq_req = 2'b00;
      wr(4'd1, 8'h00);

      // R3 status
      wr(4'd2, 8'hFF);
      rd(4'd2, 32'h60, "R3 direct bits");
      @(negedge clk); eng_busy = 2'b01;
      @(negedge clk);
      wr(4'd2, 8'h00);
      rd(4'd2, 32'h01, "R3 busy mirror");
      eng_busy = 2'b00;
      @(negedge clk); eng_err = 2'b10; eng_done = 2'b10;
      @(negedge clk); eng_err = 0; eng_done = 0;
      rd(4'd10, 32'h06, "R3 err done set");
      rd(4'd10, 32'h06, "R10 read no side effect");
      wr(4'd10, 8'h02);
      rd(4'd10, 32'h04, "R3 w1c bit1");
      wr(4'd10, 8'h04);
      rd(4'd10, 0, "R3 w1c bit2");
      // collision: error pulse with clearing write
      @(negedge clk); eng_err = 2'b01;
      @(negedge clk); eng_err = 0;
      @(negedge clk);
      eng_err = 2'b01; acc_en = 1; acc_wr = 1; acc_addr = 4'd2; acc_wdata = 32'h02; acc_size = 0;
      @(negedge clk);
      eng_err = 0; acc_en = 0; acc_wr = 0;
      rd(4'd2, 32'h02, "R3 set wins over clear");
      wr(4'd2, 8'h02);
      rd(4'd2, 0, "R3 clear after collision");

      repeat (3) @(negedge clk);
      check("R10 queue drained", DW'(exp_q.size()), 0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule